// File: doc/BRIEF.md
# Multi-mode measurement counter pair

This block holds two byte-wide counters, a low one and a high one, which can be joined into a single 16-bit counter. A small control register picks one of four ways of counting, and a second control word sets input inversion and chaining. The counting modes are:

- Count until an external event strobe arrives.
- Measure how long a data input stays high.
- Measure the time between two rising edges of the data input.
- Run freely and raise an interrupt each time the count wraps.

Every counting step is gated by a clock-enable strobe, so the count is in units of enabled cycles.

Software uses a simple register port. It writes the control word with the enable bit clear, then writes the same word with the enable bit set to start one measurement. When the measurement stops, the block raises a one-cycle interrupt. Software then reads the two count bytes. Clearing the enable bit returns the block to idle and zeroes the counters. A four-way multiplexed monitor output shows one of these signals: the raw data input, the interrupt, or the all-ones flag of either counter.

Top module: `meas_counter_pair`

## Requirements
- R1: After reset, both control words, both counters, the interrupt and the monitor output are all zero.
- R2: A write to address 0 with bit 0 clear zeroes both counters on that same clock edge. A write to address 0 with bit 0 set, made while bit 0 is clear, starts a measurement. Bits [2:1] of that write pick the mode: 00 event, 01 pulse width, 10 period, 11 free-running.
- R3: In event mode, counting starts on the first edge after the start write. The counter adds one on each edge where tick_en is high, and stops on the first edge where event_in is high. That stopping edge is not counted.
- R4: In pulse-width mode, the block first waits to see the conditioned input low and then high. It counts the tick-enabled edges on which that input is high, including the first one. It stops on the falling edge.
- R5: In period mode, counting starts on a rising edge of the conditioned input, and that edge is counted. It stops on the next rising edge, which is not counted.
- R6: Bit 0 of address 1 inverts data_in before edge detection.
- R7: In free-running mode the count never stops. The interrupt pulses once for every wrap: every 256 ticks unchained, every 65536 ticks chained. The count reads zero in the cycle of the pulse.
- R8: Bit 1 of address 1 chains the counters. The high counter then adds one when the low counter wraps from 0xFF to 0x00. Unchained, the high counter stays zero.
- R9: When a measurement stops, irq goes high for exactly one cycle, in the cycle after the stopping edge, and only once. After that, further events, edges or writes with bit 0 set leave the count unchanged. Only clearing bit 0 and then setting it again starts a new measurement.
- R10: While bit 0 of address 0 is set, writes to bits [7:1] of address 0 and all writes to address 1 are ignored. Reads return: address 0 the full control word, address 1 {6'b0, chain, invert}, address 2 the low count, address 3 the high count.
- R11: Bits [7:6] of address 0 pick the source of mon_out: 00 data_in, 01 irq, 10 low counter all ones, 11 high counter all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tick_en | input | 1 | Counting clock enable |
| data_in | input | 1 | Measured data input |
| event_in | input | 1 | Stop event strobe |
| count_lo | output | 8 | Low counter value |
| count_hi | output | 8 | High counter value |
| irq | output | 1 | One-cycle measurement or wrap interrupt |
| mon_out | output | 1 | Selected monitor signal |

## Verification
The assertions assume that every input is synchronous to clk. They also assume that software follows the start protocol: it clears the enable bit before it changes the mode, the inversion bit or the chaining bit. This is because a change of polarity while a measurement is running would look like a data edge. The stimulus drives all inputs on the falling clock edge, and it changes the inversion and chaining bits only while the block is idle. It checks on purpose that writes made while the block is enabled are ignored, so that the guarded bits cannot move under a running measurement.

// File: rtl/mcp_pkg.sv
// Shared types for the measurement counter pair.
// Assumes: a 2-bit register address space.
package mcp_pkg;
    typedef enum logic [1:0] {
        MD_EVENT  = 2'b00,
        MD_PULSE  = 2'b01,
        MD_PERIOD = 2'b10,
        MD_FREE   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_RUN  = 2'b10,
        ST_DONE = 2'b11
    } state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CFG  = 2'd1;
    localparam logic [1:0] A_LO   = 2'd2;
    localparam logic [1:0] A_HI   = 2'd3;
endpackage

// File: rtl/mcp_regs.sv
// Control and config registers with the read mux.
// Assumes: the enable bit (ctrl bit 0) guards every other control bit.
// Produces one-cycle arm/disarm strobes from writes to the control word.
module mcp_regs
    import mcp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    output logic [DW-1:0] rdata,
    output logic          en,
    output mode_e         mode,
    output mode_e         arm_mode,
    output logic          inv,
    output logic          chain,
    output logic [1:0]    sel,
    output logic          arm,
    output logic          disarm
);
    logic [7:0] ctrl_q;
    logic [1:0] cfg_q;
    logic       wr_ctrl, wr_cfg;

    assign wr_ctrl  = we && (addr == A_CTRL);
    assign wr_cfg   = we && (addr == A_CFG);
    assign arm      = wr_ctrl && wdata[0] && !ctrl_q[0];
    assign disarm   = wr_ctrl && !wdata[0];
    assign arm_mode = mode_e'(wdata[2:1]);
    assign en       = ctrl_q[0];
    assign mode     = mode_e'(ctrl_q[2:1]);
    assign sel      = ctrl_q[7:6];
    assign inv      = cfg_q[0];
    assign chain    = cfg_q[1];

    // Control word: upper bits writable only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q[0] <= wdata[0];
            if (!ctrl_q[0]) ctrl_q[7:1] <= wdata[7:1];
        end
    end

    // Config word: writable only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cfg_q <= '0;
        else if (wr_cfg && !en)     cfg_q <= wdata[1:0];
    end

    // Read mux; unused config bits read as zero.
    always_comb begin
        case (addr)
            A_CTRL:  rdata = ctrl_q;
            A_CFG:   rdata = {6'b0, cfg_q};
            A_LO:    rdata = lo;
            default: rdata = hi;
        endcase
    end

    // R10
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_cfg) |=> (cfg_q == $past(cfg_q)));
    // R10
    ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_ctrl) |=> (ctrl_q[7:1] == $past(ctrl_q[7:1])));
endmodule

// File: rtl/mcp_edge.sv
// Polarity conditioning and edge detection of the data input.
// Assumes: data_in is synchronous to clk; inv is stable during a measurement.
module mcp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic inv,
    output logic rise,
    output logic fall
);
    logic cond, cond_q;

    assign cond = din ^ inv;
    assign rise = cond && !cond_q;
    assign fall = !cond && cond_q;

    // Remember last conditioned level.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond;
    end
endmodule

// File: rtl/mcp_counters.sv
// Two stage counter chain; stage 1 steps on stage 0 carry when chained.
// Assumes: clr has priority over inc.
module mcp_counters #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic          chain,
    output logic [DW-1:0] lo,
    output logic [DW-1:0] hi,
    output logic          wrap,
    output logic          lo_full,
    output logic          hi_full
);
    localparam int NSTG = 2;

    logic [DW-1:0] cnt_q [NSTG];
    logic [NSTG:0] carry;
    logic [NSTG-1:0] step;

    assign carry[0] = inc;

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign step[g] = carry[g];
        end else begin : g_next
            assign step[g] = carry[g] && chain;
        end
        assign carry[g+1] = step[g] && (cnt_q[g] == {DW{1'b1}});

        // One counter stage: clear, step or hold.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) cnt_q[g] <= '0;
            else if (step[g])  cnt_q[g] <= cnt_q[g] + 1'b1;
        end
    end

    assign lo      = cnt_q[0];
    assign hi      = cnt_q[NSTG-1];
    assign wrap    = chain ? carry[NSTG] : carry[1];
    assign lo_full = (lo == {DW{1'b1}});
    assign hi_full = (hi == {DW{1'b1}});

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lo == '0 && hi == '0));
    // R8
    hi_unchained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain && !clr) |=> (hi == $past(hi)));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> ({hi, lo} == $past({hi, lo})));
endmodule

// File: rtl/mcp_fsm.sv
// Measurement sequencer: arm, wait for edge, run, done.
// Assumes: mode is stable while armed; disarm beats arm and counting.
module mcp_fsm
    import mcp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  arm,
    input  logic  disarm,
    input  mode_e arm_mode,
    input  mode_e mode,
    input  logic  tick,
    input  logic  evt,
    input  logic  rise,
    input  logic  fall,
    input  logic  wrap,
    output logic  inc,
    output logic  irq
);
    state_e st_q, st_nxt;
    logic   stop;

    // Next state, count step and stop condition.
    always_comb begin
        st_nxt = st_q;
        inc    = 1'b0;
        stop   = 1'b0;
        case (st_q)
            ST_WAIT: if (rise) begin
                st_nxt = ST_RUN;
                inc    = tick;
            end
            ST_RUN: begin
                case (mode)
                    MD_EVENT:  stop = evt;
                    MD_PULSE:  stop = fall;
                    MD_PERIOD: stop = rise;
                    default:   stop = 1'b0;
                endcase
                if (stop) st_nxt = ST_DONE;
                else      inc    = tick;
            end
            default: ;
        endcase
        if (disarm) inc = 1'b0;
    end

    // State register with arm/disarm override.
    always_ff @(posedge clk) begin
        if (!rst_n || disarm) st_q <= ST_IDLE;
        else if (arm)
            st_q <= (arm_mode == MD_PULSE || arm_mode == MD_PERIOD) ? ST_WAIT : ST_RUN;
        else st_q <= st_nxt;
    end

    // Registered interrupt: measurement end or free-running wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || disarm) irq <= 1'b0;
        else irq <= (st_q == ST_RUN) && (stop || (mode == MD_FREE && wrap));
    end

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE && !disarm) |=> (st_q == ST_DONE));
    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && mode != MD_FREE) |=> !irq);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !inc);
endmodule

// File: rtl/meas_counter_pair.sv
// Top of the measurement counter pair: registers, edge detector,
// sequencer and counter chain, plus the monitor output mux.
// Assumes: all inputs synchronous to clk; synchronous active-low reset.
module meas_counter_pair
    import mcp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          tick_en,
    input  logic          data_in,
    input  logic          event_in,
    output logic [DW-1:0] count_lo,
    output logic [DW-1:0] count_hi,
    output logic          irq,
    output logic          mon_out
);
    logic       en, inv, chain, arm, disarm;
    logic       rise, fall, inc, wrap, lo_full, hi_full;
    logic [1:0] sel;
    mode_e      mode, arm_mode;

    mcp_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .lo(count_lo), .hi(count_hi), .rdata(reg_rdata),
        .en(en), .mode(mode), .arm_mode(arm_mode), .inv(inv),
        .chain(chain), .sel(sel), .arm(arm), .disarm(disarm)
    );

    mcp_edge u_edge (
        .clk(clk), .rst_n(rst_n), .din(data_in), .inv(inv),
        .rise(rise), .fall(fall)
    );

    mcp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm),
        .arm_mode(arm_mode), .mode(mode), .tick(tick_en), .evt(event_in),
        .rise(rise), .fall(fall), .wrap(wrap), .inc(inc), .irq(irq)
    );

    mcp_counters #(.DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(disarm), .inc(inc), .chain(chain),
        .lo(count_lo), .hi(count_hi), .wrap(wrap),
        .lo_full(lo_full), .hi_full(hi_full)
    );

    // Monitor output source select.
    always_comb begin
        case (sel)
            2'b00:   mon_out = data_in;
            2'b01:   mon_out = irq;
            2'b10:   mon_out = lo_full;
            default: mon_out = hi_full;
        endcase
    end

    // R1
    idle_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(en)) |-> (count_lo == '0 && count_hi == '0));
endmodule

// File: tb/meas_counter_pair_test.sv
`timescale 1ns/1ps
module meas_counter_pair_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       tick_en = 1'b0;
    logic       data_in = 1'b0;
    logic       event_in = 1'b0;
    logic [7:0] count_lo, count_hi;
    logic       irq, mon_out;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    typedef struct {
        string       req;
        logic [15:0] val;
    } item_t;
    item_t sb_q[$];

    meas_counter_pair uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en),
        .data_in(data_in), .event_in(event_in), .count_lo(count_lo),
        .count_hi(count_hi), .irq(irq), .mon_out(mon_out)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic push_exp(input string req, input logic [15:0] v);
        item_t it;
        it.req = req;
        it.val = v;
        sb_q.push_back(it);
    endtask

    // Monitor: every interrupt must match the next expected count.
    always @(negedge clk) begin
        if (rst_n && irq) begin
            if (sb_q.size() == 0) begin
                chk("R9 unexpected irq", 1, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                chk(it.req, {count_hi, count_lo}, it.val);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_evt();
        event_in = 1'b1;
        @(negedge clk);
        event_in = 1'b0;
    endtask

    task automatic wait_irq(output int t);
        do @(negedge clk); while (!irq);
        t = cyc;
    endtask

    task automatic finish_run();
        chk("R9 all expected irqs seen", sb_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk("watchdog", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int t0, t1, t2, n;

        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd1, v); chk("R1 cfg", v, 0);
        chk("R1 counts", {count_hi, count_lo}, 0);
        chk("R1 irq", irq, 0);
        chk("R1 mon_out", mon_out, 0);

        // R3 event mode, 20 ticks
        wr(2'd0, 8'h01);
        tick_en = 1'b1;
        idle(20);
        push_exp("R3 event count", 16'd20);
        pulse_evt();
        idle(3);
        // R9 held after more events and a repeated start write
        pulse_evt();
        wr(2'd0, 8'h01);
        idle(5);
        chk("R9 count held", {count_hi, count_lo}, 20);
        // R10 writes ignored while enabled
        wr(2'd0, 8'hC7);
        rd(2'd0, v); chk("R10 ctrl locked", v, 8'h01);
        wr(2'd1, 8'h03);
        rd(2'd1, v); chk("R10 cfg locked", v, 8'h00);
        // R2 disabling write clears counts on that edge
        wr(2'd0, 8'h00);
        chk("R2 clear", {count_hi, count_lo}, 0);

        // R3 gated ticks
        wr(2'd0, 8'h01);
        n = 0;
        for (int i = 0; i < 30; i++) begin
            tick_en = (i % 3) != 0;
            if (tick_en) n++;
            @(negedge clk);
        end
        tick_en = 1'b1;
        push_exp("R3 gated count", 16'(n));
        pulse_evt();
        wr(2'd0, 8'h00);

        // R4 pulse width, 13 cycles high
        data_in = 1'b0;
        wr(2'd0, 8'h03);
        idle(3);
        data_in = 1'b1;
        idle(13);
        push_exp("R4 pulse width", 16'd13);
        data_in = 1'b0;
        idle(3);
        wr(2'd0, 8'h00);

        // R4 input already high at start: waits for a fresh rise
        data_in = 1'b1;
        idle(2);
        wr(2'd0, 8'h03);
        idle(5);
        chk("R4 no count while high at start", {count_hi, count_lo}, 0);
        data_in = 1'b0;
        idle(3);
        data_in = 1'b1;
        idle(9);
        push_exp("R4 pulse after wait", 16'd9);
        data_in = 1'b0;
        idle(3);
        wr(2'd0, 8'h00);

        // R5 period: 4 high + 6 low
        wr(2'd0, 8'h05);
        idle(3);
        data_in = 1'b1;
        idle(4);
        data_in = 1'b0;
        idle(6);
        push_exp("R5 period", 16'd10);
        data_in = 1'b1;
        idle(1);
        data_in = 1'b0;
        idle(3);
        wr(2'd0, 8'h00);

        // R6 inverted pulse width measures a low pulse
        data_in = 1'b1;
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h03);
        idle(3);
        data_in = 1'b0;
        idle(7);
        push_exp("R6 inverted pulse", 16'd7);
        data_in = 1'b1;
        idle(3);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        data_in = 1'b0;

        // R8 chained 300 ticks
        wr(2'd1, 8'h02);
        wr(2'd0, 8'h01);
        idle(300);
        push_exp("R8 chained count", 16'h012C);
        pulse_evt();
        rd(2'd2, v); chk("R8 low read", v, 8'h2C);
        rd(2'd3, v); chk("R8 high read", v, 8'h01);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        // R8 unchained 300 ticks
        wr(2'd0, 8'h01);
        idle(300);
        push_exp("R8 unchained count", 16'h002C);
        pulse_evt();
        chk("R8 high stays zero", count_hi, 0);
        wr(2'd0, 8'h00);

        // R11 monitor select
        data_in = 1'b1; #0.5;
        chk("R11 sel data high", mon_out, 1);
        data_in = 1'b0; #0.5;
        chk("R11 sel data low", mon_out, 0);
        wr(2'd0, 8'h40);
        chk("R11 sel irq", mon_out, 0);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h81);
        chk("R11 low flag clear", mon_out, 0);
        idle(255);
        push_exp("R11 count ff", 16'h00FF);
        pulse_evt();
        chk("R11 low flag set", mon_out, 1);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'hC0);
        chk("R11 high flag clear", mon_out, 0);
        wr(2'd0, 8'h00);

        // R7 free-running unchained: period 256
        wr(2'd0, 8'h07);
        t0 = cyc;
        push_exp("R7 wrap count", 16'd0);
        push_exp("R7 wrap count", 16'd0);
        wait_irq(t1);
        chk("R7 first wrap", t1 - t0, 256);
        wait_irq(t2);
        chk("R7 wrap period", t2 - t1, 256);
        wr(2'd0, 8'h00);

        // R7 free-running chained: period 65536
        wr(2'd1, 8'h02);
        wr(2'd0, 8'h07);
        t0 = cyc;
        push_exp("R7 chained wrap count", 16'd0);
        wait_irq(t1);
        chk("R7 chained wrap", t1 - t0, 65536);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        idle(4);

        finish_run();
    end
endmodule